// File: doc/BRIEF.md
# Transmit Ring Pointer Manager

This block holds the addressing state for eight independent transmit descriptor rings. For each ring it keeps a base address chosen by software, a current-descriptor pointer and a frame-start mark. Every stored address is 8-byte aligned. A DMA engine reports descriptor events, one per cycle, each tagged with a ring index. The block moves the pointer forward by one descriptor, wraps it to the base, or rolls it back to the start of a frame that failed. The DMA engine picks a ring and reads that ring's current pointer and enable back from the block.

Software sees three registers per ring through a flat register port: base, pointer and control. Software may redirect a ring by writing its pointer, but only while the ring is disabled or idle between frames. If the DMA engine reports an event for the same ring in the same cycle, the event takes priority over the software write.

Top module: `txring_ptr_mgr`

## Requirements
- R1: The eight rings are independent. An event or register write aimed at one ring leaves the base, pointer and enable of every other ring unchanged.
- R2: Bits [2:0] of every base and pointer register read as zero. Writes to those bits are ignored.
- R3: A close event (op 1) with the wrap flag clear advances that ring's pointer by 8 bytes, modulo 2^32.
- R4: A close event with the wrap flag set loads that ring's pointer from that ring's base register.
- R5: An error event (op 2) sets that ring's pointer back to the ring's frame-start mark and leaves the ring idle.
- R6: A take event (op 0) with the first flag set records the current pointer as the frame-start mark and makes the ring busy. A take event does not move the pointer. A close event with the last flag set sets the frame-start mark to the new pointer and makes the ring idle.
- R7: A software write to a pointer register updates the pointer and the frame-start mark only when that ring is disabled or idle. Otherwise the write is ignored.
- R8: When a DMA event and a software pointer write reach the same ring in the same cycle, only the DMA event takes effect.
- R9: After reset every register of every ring reads as zero, and every ring is disabled and idle.
- R10: dma_ptr_o and dma_en_o show the pointer and enable of the ring selected by dma_ring_i. A pointer change caused by an event shows on these outputs after the next rising clock edge and not before it.
- R11: The register address is {ring[2:0], sel[1:0]}. sel 0 selects base, sel 1 selects pointer, sel 2 selects control, whose bit 0 is the ring enable, and sel 3 reads zero. Reads are combinational. An event with op 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | A DMA event is present this cycle |
| evt_ring_i | input | 3 | Ring index of the event |
| evt_op_i | input | 2 | Event op: 0 take, 1 close, 2 error, 3 none |
| evt_first_i | input | 1 | Taken descriptor starts a frame |
| evt_wrap_i | input | 1 | Closed descriptor is the last one in the ring |
| evt_last_i | input | 1 | Closed descriptor ends a frame |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address {ring, sel} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| dma_ring_i | input | 3 | Ring selected by the DMA engine |
| dma_ptr_o | output | 32 | Current pointer of the selected ring |
| dma_en_o | output | 1 | Enable of the selected ring |

## Verification
Pointer movement is tested with several event sequences on one ring. A frame of two descriptors separates a plain close from a close that ends a frame. A rolled-back frame shows whether the frame-start mark was taken at the first descriptor or at the last close. A close with the wrap flag shows whether the pointer loads from base or from an increment. A close at address 0xFFFF_FFF8 on the top ring index checks the modulo wrap of the address and the decode of the highest ring. Pointer writes while busy, while idle, and in the same cycle as an event separate the three outcomes of write arbitration. Reads of an untouched ring after all of this traffic show any leak between rings.

// File: rtl/txring_pkg.sv
package txring_pkg;
  typedef enum logic [1:0] {
    EVT_TAKE  = 2'd0,
    EVT_CLOSE = 2'd1,
    EVT_ERROR = 2'd2,
    EVT_NONE  = 2'd3
  } evt_op_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/txring_slot.sv
module txring_slot
  import txring_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_hit_i,
  input  evt_op_e           evt_op_i,
  input  logic              evt_first_i,
  input  logic              evt_wrap_i,
  input  logic              evt_last_i,
  input  logic              wr_base_i,
  input  logic              wr_ptr_i,
  input  logic              wr_ctrl_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              en_o
);
  localparam int unsigned SW = ADDR_W - ALIGN_W;

  logic [SW-1:0] base_q, ptr_q, fstart_q;
  logic [SW-1:0] ptr_d, fstart_d, step;
  logic          en_q, busy_q, busy_d;
  logic          sw_ptr_ok;

  // event beats software; software only while disabled or between frames
  assign sw_ptr_ok = wr_ptr_i && !evt_hit_i && (!en_q || !busy_q);
  assign step      = evt_wrap_i ? base_q : ptr_q + SW'(1);

  always_comb begin
    ptr_d    = ptr_q;
    fstart_d = fstart_q;
    busy_d   = busy_q;
    if (evt_hit_i) begin
      case (evt_op_i)
        EVT_TAKE: begin
          if (evt_first_i) begin
            fstart_d = ptr_q;
            busy_d   = 1'b1;
          end
        end
        EVT_CLOSE: begin
          ptr_d = step;
          if (evt_last_i) begin
            fstart_d = step;
            busy_d   = 1'b0;
          end
        end
        EVT_ERROR: begin
          ptr_d  = fstart_q;
          busy_d = 1'b0;
        end
        default: ;
      endcase
    end else if (sw_ptr_ok) begin
      ptr_d    = wdata_i[ADDR_W-1:ALIGN_W];
      fstart_d = wdata_i[ADDR_W-1:ALIGN_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      ptr_q    <= '0;
      fstart_q <= '0;
      en_q     <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      fstart_q <= fstart_d;
      busy_q   <= busy_d;
      if (wr_base_i) base_q <= wdata_i[ADDR_W-1:ALIGN_W];
      if (wr_ctrl_i) en_q   <= wdata_i[0];
    end
  end

  assign base_o = {base_q, {ALIGN_W{1'b0}}};
  assign ptr_o  = {ptr_q, {ALIGN_W{1'b0}}};
  assign en_o   = en_q;

  AST_CLOSE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hit_i && evt_op_i == EVT_CLOSE && !evt_wrap_i) |=> ptr_q == $past(ptr_q) + SW'(1)); // R3
  AST_CLOSE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hit_i && evt_op_i == EVT_CLOSE && evt_wrap_i) |=> ptr_q == $past(base_q)); // R4
  AST_ERR_ROLLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hit_i && evt_op_i == EVT_ERROR) |=> (ptr_q == $past(fstart_q) && !busy_q)); // R5
  AST_FIRST_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hit_i && evt_op_i == EVT_TAKE && evt_first_i) |=> (fstart_q == $past(ptr_q) && busy_q && $stable(ptr_q))); // R6
  AST_BUSY_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_i && !evt_hit_i && en_q && busy_q) |=> $stable(ptr_q)); // R7
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_i && evt_hit_i && evt_op_i == EVT_NONE) |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/txring_evt_dec.sv
module txring_evt_dec #(
  parameter int unsigned NUM_RINGS = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_RINGS)
) (
  input  logic                 evt_valid_i,
  input  logic [IDX_W-1:0]     evt_ring_i,
  output logic [NUM_RINGS-1:0] evt_hit_o
);
  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_hit
    assign evt_hit_o[g] = evt_valid_i && (evt_ring_i == IDX_W'(g));
  end
endmodule

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
#(
  parameter int unsigned NUM_RINGS = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = $clog2(NUM_RINGS),
  parameter int unsigned RA_W      = IDX_W + SEL_W
) (
  input  logic                             reg_wr_i,
  input  logic [RA_W-1:0]                  reg_addr_i,
  input  logic [NUM_RINGS-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_RINGS-1:0][ADDR_W-1:0] ptr_i,
  input  logic [NUM_RINGS-1:0]             en_i,
  output logic [NUM_RINGS-1:0]             wr_base_o,
  output logic [NUM_RINGS-1:0]             wr_ptr_o,
  output logic [NUM_RINGS-1:0]             wr_ctrl_o,
  output logic [ADDR_W-1:0]                rdata_o
);
  logic [IDX_W-1:0] ring;
  reg_sel_e         sel;

  assign ring = reg_addr_i[RA_W-1:SEL_W];
  assign sel  = reg_sel_e'(reg_addr_i[SEL_W-1:0]);

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_wr
    logic hit;
    assign hit          = reg_wr_i && (ring == IDX_W'(g));
    assign wr_base_o[g] = hit && (sel == SEL_BASE);
    assign wr_ptr_o[g]  = hit && (sel == SEL_PTR);
    assign wr_ctrl_o[g] = hit && (sel == SEL_CTRL);
  end

  always_comb begin
    rdata_o = '0;
    if (int'(ring) < NUM_RINGS) begin
      case (sel)
        SEL_BASE: rdata_o = base_i[ring];
        SEL_PTR:  rdata_o = ptr_i[ring];
        SEL_CTRL: rdata_o = {{(ADDR_W-1){1'b0}}, en_i[ring]};
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/txring_ptr_mgr.sv
module txring_ptr_mgr
  import txring_pkg::*;
#(
  parameter int unsigned NUM_RINGS = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ALIGN_W   = 3,
  parameter int unsigned IDX_W     = $clog2(NUM_RINGS),
  parameter int unsigned RA_W      = IDX_W + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [IDX_W-1:0]  evt_ring_i,
  input  logic [1:0]        evt_op_i,
  input  logic              evt_first_i,
  input  logic              evt_wrap_i,
  input  logic              evt_last_i,
  input  logic              reg_wr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic [IDX_W-1:0]  dma_ring_i,
  output logic [ADDR_W-1:0] dma_ptr_o,
  output logic              dma_en_o
);
  logic [NUM_RINGS-1:0]             evt_hit, wr_base, wr_ptr, wr_ctrl, en_all;
  logic [NUM_RINGS-1:0][ADDR_W-1:0] base_all, ptr_all;
  evt_op_e                          op;

  assign op = evt_op_e'(evt_op_i);

  txring_evt_dec #(.NUM_RINGS(NUM_RINGS), .IDX_W(IDX_W)) u_evt_dec (
    .evt_valid_i (evt_valid_i),
    .evt_ring_i  (evt_ring_i),
    .evt_hit_o   (evt_hit)
  );

  txring_regs #(.NUM_RINGS(NUM_RINGS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .RA_W(RA_W)) u_regs (
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .base_i     (base_all),
    .ptr_i      (ptr_all),
    .en_i       (en_all),
    .wr_base_o  (wr_base),
    .wr_ptr_o   (wr_ptr),
    .wr_ctrl_o  (wr_ctrl),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    txring_slot #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_hit_i   (evt_hit[g]),
      .evt_op_i    (op),
      .evt_first_i (evt_first_i),
      .evt_wrap_i  (evt_wrap_i),
      .evt_last_i  (evt_last_i),
      .wr_base_i   (wr_base[g]),
      .wr_ptr_i    (wr_ptr[g]),
      .wr_ctrl_i   (wr_ctrl[g]),
      .wdata_i     (reg_wdata_i),
      .base_o      (base_all[g]),
      .ptr_o       (ptr_all[g]),
      .en_o        (en_all[g])
    );
  end

  always_comb begin
    dma_ptr_o = '0;
    dma_en_o  = 1'b0;
    if (int'(dma_ring_i) < NUM_RINGS) begin
      dma_ptr_o = ptr_all[dma_ring_i];
      dma_en_o  = en_all[dma_ring_i];
    end
  end

  // checker state: which rings moved on the last edge
  logic [NUM_RINGS-1:0][ADDR_W-1:0] ptr_prev_q;
  logic [NUM_RINGS-1:0]             moved;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_prev_q <= '0;
    else         ptr_prev_q <= ptr_all;
  end
  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_moved
    assign moved[g] = ptr_all[g] != ptr_prev_q[g];
  end

  AST_ONE_RING_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> $countones(moved) <= 1); // R1
  AST_NO_EVT_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_valid_i && !reg_wr_i) |=> moved == '0); // R10
endmodule

// File: tb/txring_ptr_mgr_tb.sv
module txring_ptr_mgr_tb;
  localparam time TCLK = 20ns;
  localparam int  NV   = 24;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic [2:0]  evt_ring_i = '0;
  logic [1:0]  evt_op_i = 2'd3;
  logic        evt_first_i = 1'b0, evt_wrap_i = 1'b0, evt_last_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, dma_ptr_o;
  logic [2:0]  dma_ring_i = '0;
  logic        dma_en_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(TCLK/2) clk_i = ~clk_i;

  txring_ptr_mgr u_dut (
    .clk_i, .rst_ni, .evt_valid_i, .evt_ring_i, .evt_op_i, .evt_first_i,
    .evt_wrap_i, .evt_last_i, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .dma_ring_i, .dma_ptr_o, .dma_en_o
  );

  // {kind[77:76] 0=write 1=event, ring[75:73], sel/op[72:71], {first,wrap,last}[70:68],
  //  data[67:36], expected ptr of ring[35:4], req[3:0]}
  localparam logic [77:0] VEC [NV] = '{
    {2'd0, 3'd2, 2'd0, 3'b000, 32'h1000_0007, 32'h0000_0000, 4'd11}, // R11 base write
    {2'd0, 3'd2, 2'd1, 3'b000, 32'h1000_0000, 32'h1000_0000, 4'd7},  // R7 disabled write
    {2'd0, 3'd2, 2'd2, 3'b000, 32'h0000_0001, 32'h1000_0000, 4'd11}, // R11 enable
    {2'd1, 3'd2, 2'd0, 3'b100, 32'h0,         32'h1000_0000, 4'd6},  // R6 take first
    {2'd1, 3'd2, 2'd1, 3'b000, 32'h0,         32'h1000_0008, 4'd3},  // R3
    {2'd1, 3'd2, 2'd0, 3'b000, 32'h0,         32'h1000_0008, 4'd6},  // R6 take mid
    {2'd1, 3'd2, 2'd1, 3'b001, 32'h0,         32'h1000_0010, 4'd3},  // R3 last
    {2'd1, 3'd2, 2'd0, 3'b100, 32'h0,         32'h1000_0010, 4'd6},  // R6
    {2'd1, 3'd2, 2'd1, 3'b000, 32'h0,         32'h1000_0018, 4'd3},  // R3
    {2'd1, 3'd2, 2'd1, 3'b000, 32'h0,         32'h1000_0020, 4'd3},  // R3
    {2'd1, 3'd2, 2'd2, 3'b000, 32'h0,         32'h1000_0010, 4'd5},  // R5 rollback
    {2'd1, 3'd2, 2'd0, 3'b100, 32'h0,         32'h1000_0010, 4'd6},  // R6
    {2'd1, 3'd2, 2'd1, 3'b011, 32'h0,         32'h1000_0000, 4'd4},  // R4 wrap
    {2'd1, 3'd2, 2'd0, 3'b100, 32'h0,         32'h1000_0000, 4'd6},  // R6
    {2'd0, 3'd2, 2'd1, 3'b000, 32'h2000_0000, 32'h1000_0000, 4'd7},  // R7 busy: dropped
    {2'd1, 3'd2, 2'd1, 3'b001, 32'h0,         32'h1000_0008, 4'd3},  // R3
    {2'd0, 3'd2, 2'd1, 3'b000, 32'h2000_0005, 32'h2000_0000, 4'd2},  // R2 low bits
    {2'd1, 3'd2, 2'd0, 3'b100, 32'h0,         32'h2000_0000, 4'd6},  // R6
    {2'd1, 3'd2, 2'd1, 3'b000, 32'h0,         32'h2000_0008, 4'd3},  // R3
    {2'd1, 3'd2, 2'd2, 3'b000, 32'h0,         32'h2000_0000, 4'd5},  // R5
    {2'd0, 3'd7, 2'd0, 3'b000, 32'hFFFF_FFF8, 32'h0000_0000, 4'd1},  // R1 top ring
    {2'd0, 3'd7, 2'd1, 3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFF8, 4'd2},  // R2
    {2'd1, 3'd7, 2'd1, 3'b000, 32'h0,         32'h0000_0000, 4'd3},  // R3 modulo
    {2'd1, 3'd7, 2'd1, 3'b010, 32'h0,         32'hFFFF_FFF8, 4'd4}   // R4
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_valid_i = 1'b0; evt_op_i = 2'd3;
    evt_first_i = 1'b0; evt_wrap_i = 1'b0; evt_last_i = 1'b0;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] addr, input logic [31:0] exp, input string req);
    reg_addr_i = addr;
    #1;
    check(reg_rdata_o, exp, req);
  endtask

  initial begin
    #(TCLK * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: everything zero in reset and after release
    for (int a = 0; a < 32; a++) rd(5'(a), 32'h0, "R9");
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int r = 0; r < 8; r++) begin
      dma_ring_i = 3'(r);
      #1;
      check(dma_ptr_o, 32'h0, "R9");
      check({31'b0, dma_en_o}, 32'h0, "R9");
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      v = VEC[i];
      if (v[77:76] == 2'd0) begin
        reg_wr_i    = 1'b1;
        reg_addr_i  = {v[75:73], v[72:71]};
        reg_wdata_i = v[67:36];
      end else begin
        evt_valid_i = 1'b1;
        evt_ring_i  = v[75:73];
        evt_op_i    = v[72:71];
        {evt_first_i, evt_wrap_i, evt_last_i} = v[70:68];
      end
      @(negedge clk_i);
      idle_inputs();
      dma_ring_i = v[75:73];
      #1;
      check(dma_ptr_o, v[35:4], $sformatf("R%0d vec %0d", v[3:0], i));
    end

    // R1: untouched ring 5
    rd({3'd5, 2'd0}, 32'h0, "R1");
    rd({3'd5, 2'd1}, 32'h0, "R1");
    rd({3'd5, 2'd2}, 32'h0, "R1");
    // R2: base low bits dropped; R11 control and reserved
    rd({3'd2, 2'd0}, 32'h1000_0000, "R2");
    rd({3'd2, 2'd2}, 32'h1, "R11");
    rd({3'd2, 2'd3}, 32'h0, "R11");
    rd({3'd7, 2'd1}, 32'hFFFF_FFF8, "R11");
    dma_ring_i = 3'd2; #1;
    check({31'b0, dma_en_o}, 32'h1, "R10");
    dma_ring_i = 3'd7; #1;
    check({31'b0, dma_en_o}, 32'h0, "R10");

    // R8: event and pointer write on ring 2 in one cycle (ring idle, enabled)
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_ring_i = 3'd2; evt_op_i = 2'd1;
    reg_wr_i = 1'b1; reg_addr_i = {3'd2, 2'd1}; reg_wdata_i = 32'h3000_0000;
    @(negedge clk_i);
    idle_inputs();
    dma_ring_i = 3'd2; #1;
    check(dma_ptr_o, 32'h2000_0008, "R8");

    // R11: op 3 has no effect
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_ring_i = 3'd2; evt_op_i = 2'd3; evt_wrap_i = 1'b1;
    @(negedge clk_i);
    idle_inputs(); #1;
    check(dma_ptr_o, 32'h2000_0008, "R11");

    // R10: change visible only after the edge
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_ring_i = 3'd2; evt_op_i = 2'd1;
    #1;
    check(dma_ptr_o, 32'h2000_0008, "R10");
    @(posedge clk_i); #1;
    check(dma_ptr_o, 32'h2000_0010, "R10");
    @(negedge clk_i);
    idle_inputs();

    // R7: ring disabled while busy accepts the write
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_ring_i = 3'd2; evt_op_i = 2'd0; evt_first_i = 1'b1;
    @(negedge clk_i);
    idle_inputs();
    reg_wr_i = 1'b1; reg_addr_i = {3'd2, 2'd2}; reg_wdata_i = 32'h0;
    @(negedge clk_i);
    reg_addr_i = {3'd2, 2'd1}; reg_wdata_i = 32'h4000_0008;
    @(negedge clk_i);
    idle_inputs(); #1;
    check(dma_ptr_o, 32'h4000_0008, "R7");
    // rollback target follows the written pointer
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_ring_i = 3'd2; evt_op_i = 2'd2;
    @(negedge clk_i);
    idle_inputs(); #1;
    check(dma_ptr_o, 32'h4000_0008, "R5");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule